// File: doc/BRIEF.md
# Dual-Output Fast-Read Serializer

This block is the device-side read path of a serial flash. While chip select is low it takes a command byte and a 24-bit start address on a single input line. For the fast commands it waits through a dummy byte. It then streams bytes fetched from a synchronous memory port with an incrementing address, until chip select rises. Inputs are sampled on the rising clock edge and outputs change on the falling edge.

Three read commands are served. The plain read sends data on the dedicated output line with no dummy byte. The fast read adds eight dummy clocks. The dual read also adds the dummy byte, then turns the bidirectional pin around into a second output, so a byte goes out every four clocks. The next byte is always fetched ahead of time, so streaming has no bubbles. A command that arrives while the array reports a busy write or erase cycle is dropped.

Top module: `dual_read_serializer`

## Requirements
- R1: The command byte is sampled MSB first on the first eight rising edges after chip select falls. Only 03h (plain read), 0Bh (fast read) and 3Bh (dual read) are served. Any other code leaves both outputs undriven and issues no memory read until chip select rises.
- R2: For a plain read, bit 7 of the first byte appears on `soOut` at the falling edge that follows the rising edge sampling the last address bit. Each later falling edge moves one bit lower, MSB first.
- R3: For fast and dual reads, eight dummy clocks follow the address, and the values on `dioIn` during them have no effect on the data returned.
- R4: For a dual read, each falling edge drives one bit pair: `soOut` carries bits 7,5,3,1 and `dioOut` carries bits 6,4,2,0, higher pair first, with four clocks per byte.
- R5: Bytes stream without gaps from consecutive addresses for as long as chip select stays low.
- R6: The address counter has 21 bits. Address bits 23..21 are ignored, and the address after 1FFFFFh is 000000h.
- R7: A command whose last bit is sampled while `busy` is high is ignored: no output is driven and no memory read is issued.
- R8: `soOe` and `dioOe` are low while chip select is high and during the command, address and dummy phases. `dioOe` is high only in the data phase of a dual read, and `soOe` is high in every data phase.
- R9: A rise of chip select ends the transfer at any bit position, and the next transfer starts again from the command byte.
- R10: The memory port has a one-cycle read latency. The first read carries the start address, and later reads carry consecutive addresses, each issued before the byte is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| busy | input | 1 | Array busy with a write, erase or status cycle |
| dioIn | input | 1 | Input side of the bidirectional pin (command, address, dummy) |
| dioOut | output | 1 | Output side of the bidirectional pin (even bits in dual mode) |
| dioOe | output | 1 | Drive enable of the bidirectional pin |
| soOut | output | 1 | Dedicated data output (all bits single, odd bits dual) |
| soOe | output | 1 | Drive enable of the dedicated output |
| memRdEn | output | 1 | Memory read strobe |
| memAddr | output | 21 | Memory read address |
| memData | input | 8 | Memory read data, valid one cycle after the strobe |

## Verification
A phase counter that is off by one shifts every returned byte by one bit position. It also moves the output-enable rise off the first falling edge after the header, so the first byte compare catches it within eight clocks of the address. A fault in the prefetch or address counter shows as a wrong or repeated byte at the first byte boundary, and as a read-address sequence that is not consecutive. Dual mode catches it within four clocks. Lane swaps, a missed turnaround of the bidirectional pin, or a leaked drive enable after chip select rises show up in the bit-pair compares and in the enable sample taken right after each transfer.

// File: rtl/rdser_pkg.sv
`timescale 1ns/1ps
package rdser_pkg;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] OP_DUAL = 8'h3B;
  localparam int OP_BITS = 8;

  typedef enum logic [2:0] {ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_IGNORE} phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;         // chip select high: abandon transfer
    logic addrShift;   // shift address bit in
    logic hdrDone;     // last header bit sampled this cycle
    logic addrFromReg; // start address already complete in register
    logic dataPhase;   // streaming data
    logic dual;        // two-lane output
  } strobe_t;
endpackage

// File: rtl/rdser_ctrl.sv
`timescale 1ns/1ps
module rdser_ctrl
  import rdser_pkg::*;
#(
  parameter int ADDR_BITS  = 24,
  parameter int DUMMY_BITS = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    busy,
  input  logic    dioIn,
  output strobe_t stb
);
  localparam int CW = $clog2(ADDR_BITS + 1);

  phase_e        state;
  logic [CW-1:0] cnt;
  logic [6:0]    opSh;
  logic          fastR;
  logic          dualR;
  logic [7:0]    opFull;
  logic          opValid;
  logic          lastOp, lastAddr, lastDummy;

  assign opFull    = {opSh, dioIn};
  assign opValid   = (opFull == OP_READ) || (opFull == OP_FAST) || (opFull == OP_DUAL);
  assign lastOp    = (cnt == CW'(OP_BITS - 1));
  assign lastAddr  = (cnt == CW'(ADDR_BITS - 1));
  assign lastDummy = (cnt == CW'(DUMMY_BITS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_CMD;
      cnt   <= '0;
      opSh  <= '0;
      fastR <= 1'b0;
      dualR <= 1'b0;
    end else if (csN) begin
      state <= ST_CMD;
      cnt   <= '0;
      fastR <= 1'b0;
      dualR <= 1'b0;
    end else begin
      case (state)
        ST_CMD: begin
          opSh <= opFull[6:0];
          cnt  <= cnt + 1'b1;
          if (lastOp) begin
            cnt <= '0;
            if (!busy && opValid) begin
              state <= ST_ADDR;
              fastR <= (opFull != OP_READ);
              dualR <= (opFull == OP_DUAL);
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_ADDR: begin
          cnt <= cnt + 1'b1;
          if (lastAddr) begin
            cnt   <= '0;
            state <= fastR ? ST_DUMMY : ST_DATA;
          end
        end
        ST_DUMMY: begin
          cnt <= cnt + 1'b1;
          if (lastDummy) begin
            cnt   <= '0;
            state <= ST_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    stb.clr         = csN;
    stb.addrShift   = !csN && (state == ST_ADDR);
    stb.hdrDone     = !csN && (((state == ST_ADDR) && lastAddr && !fastR) ||
                               ((state == ST_DUMMY) && lastDummy));
    stb.addrFromReg = (state == ST_DUMMY);
    stb.dataPhase   = (state == ST_DATA);
    stb.dual        = dualR;
  end

  // R1: data phase is entered only from the end of a header
  a_r1_data_after_header: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.dataPhase) |-> ($past(state) == ST_ADDR || $past(state) == ST_DUMMY));

  // R7: a command finishing under busy is dropped
  a_r7_busy_drops: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CMD && lastOp && busy && !csN) |=> (state == ST_IGNORE));

  // R9: chip select high restarts at the command byte
  a_r9_cs_restart: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (state == ST_CMD && cnt == '0));
endmodule

// File: rtl/rdser_dp.sv
`timescale 1ns/1ps
module rdser_dp
  import rdser_pkg::*;
#(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic          dioIn,
  output logic          memRdEn,
  output logic [AW-1:0] memAddr,
  input  logic [7:0]    memData,
  output logic          soOut,
  output logic          soOe,
  output logic          dioOut,
  output logic          dioOe
);
  logic [AW-1:0] addrSh;
  logic [AW-1:0] addrCnt;
  logic [AW-1:0] startA;
  logic [7:0]    shReg;
  logic [7:0]    pfReg;
  logic [7:0]    srcByte;
  logic [7:0]    nextShift;
  logic          pfValid;
  logic          rdPend;
  logic          useMem;
  logic [2:0]    emitCnt;
  logic [2:0]    lastEmit;
  logic          rdFetch;
  logic          soOutR, dioOutR, soOeR, dioOeR;

  assign startA    = stb.addrFromReg ? addrSh : {addrSh[AW-2:0], dioIn};
  assign srcByte   = useMem ? memData : shReg;
  assign nextShift = stb.dual ? {srcByte[5:0], 2'b00} : {srcByte[6:0], 1'b0};
  assign lastEmit  = stb.dual ? 3'd3 : 3'd7;
  assign rdFetch   = stb.dataPhase && !stb.clr && !pfValid && !rdPend;
  assign memRdEn   = stb.hdrDone || rdFetch;
  assign memAddr   = stb.hdrDone ? startA : addrCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrSh  <= '0;
      addrCnt <= '0;
      shReg   <= '0;
      pfReg   <= '0;
      pfValid <= 1'b0;
      rdPend  <= 1'b0;
      useMem  <= 1'b0;
      emitCnt <= '0;
    end else if (stb.clr) begin
      pfValid <= 1'b0;
      rdPend  <= 1'b0;
      useMem  <= 1'b0;
      emitCnt <= '0;
    end else begin
      if (stb.addrShift) addrSh <= {addrSh[AW-2:0], dioIn};
      if (stb.hdrDone) begin
        addrCnt <= startA + 1'b1;
        useMem  <= 1'b1;
        emitCnt <= '0;
      end
      if (rdFetch) begin
        rdPend  <= 1'b1;
        addrCnt <= addrCnt + 1'b1;
      end
      if (rdPend) begin
        pfReg   <= memData;
        pfValid <= 1'b1;
        rdPend  <= 1'b0;
      end
      if (stb.dataPhase) begin
        useMem <= 1'b0;
        if (emitCnt == lastEmit) begin
          shReg   <= pfReg;
          pfValid <= 1'b0;
          emitCnt <= '0;
        end else begin
          shReg   <= nextShift;
          emitCnt <= emitCnt + 1'b1;
        end
      end
    end
  end

  // launch on the falling edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      soOutR  <= 1'b0;
      dioOutR <= 1'b0;
      soOeR   <= 1'b0;
      dioOeR  <= 1'b0;
    end else begin
      soOutR  <= srcByte[7];
      dioOutR <= srcByte[6];
      soOeR   <= stb.dataPhase && !stb.clr;
      dioOeR  <= stb.dataPhase && stb.dual && !stb.clr;
    end
  end

  assign soOut  = soOutR;
  assign dioOut = dioOutR;
  assign soOe   = soOeR && !stb.clr;
  assign dioOe  = dioOeR && !stb.clr;

  // R10: a byte boundary always finds the next byte prefetched
  a_r10_reload_ready: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dataPhase && !stb.clr && !useMem && emitCnt == lastEmit) |-> pfValid);

  // R10: at most one byte in flight or held
  a_r10_single_pending: assert property (@(posedge clk) disable iff (!rstN)
    rdPend |-> !pfValid);

  // R8: the bidirectional pin drives only alongside the dedicated output
  a_r8_bidir_with_so: assert property (@(posedge clk) disable iff (!rstN)
    dioOe |-> soOe);
endmodule

// File: rtl/dual_read_serializer.sv
`timescale 1ns/1ps
module dual_read_serializer
  import rdser_pkg::*;
#(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          busy,
  input  logic          dioIn,
  output logic          dioOut,
  output logic          dioOe,
  output logic          soOut,
  output logic          soOe,
  output logic          memRdEn,
  output logic [AW-1:0] memAddr,
  input  logic [7:0]    memData
);
  strobe_t stb;

  rdser_ctrl #(.ADDR_BITS(24), .DUMMY_BITS(8)) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .busy(busy), .dioIn(dioIn), .stb(stb)
  );

  rdser_dp #(.AW(AW)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .dioIn(dioIn),
    .memRdEn(memRdEn), .memAddr(memAddr), .memData(memData),
    .soOut(soOut), .soOe(soOe), .dioOut(dioOut), .dioOe(dioOe)
  );
endmodule

// File: tb/dual_read_serializer_tb_top.sv
`timescale 1ns/1ps
module dual_read_serializer_tb_top;
  localparam int AW = 21;
  localparam logic [AW-1:0] MASK = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic busy = 1'b0;
  logic dioIn = 1'b0;
  logic dioOut, dioOe, soOut, soOe, memRdEn;
  logic [AW-1:0] memAddr;
  logic [7:0] memData = 8'h00;

  int nChecks = 0;
  int nFails = 0;
  int rdN = 0;
  logic [AW-1:0] reads [1024];
  bit done = 0;

  always #10 clk = ~clk;

  dual_read_serializer #(.AW(AW)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .busy(busy), .dioIn(dioIn),
    .dioOut(dioOut), .dioOe(dioOe), .soOut(soOut), .soOe(soOe),
    .memRdEn(memRdEn), .memAddr(memAddr), .memData(memData)
  );

  function automatic logic [7:0] memf(input logic [AW-1:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ {3'b000, a[20:16]};
  endfunction

  // synchronous memory model, one-cycle latency
  always @(posedge clk) begin
    if (memRdEn) begin
      memData <= memf(memAddr);
      reads[rdN % 1024] = memAddr;
      rdN++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, inout bit oeBad);
    @(negedge clk);
    csN = 1'b0;
    dioIn = b;
    @(posedge clk);
    #1;
    if (soOe || dioOe) oeBad = 1;
  endtask

  // one transfer; extra = bit emissions of a partial byte before chip select rises
  task automatic runRead(input logic [7:0] op, input logic [23:0] addr, input int nBytes,
                         input logic dumVal, input logic busyVal, input bit ignored,
                         input int extra, input string tag);
    bit dual = (op == 8'h3B);
    bit fast = (op != 8'h03);
    int per = dual ? 4 : 8;
    bit hdrOeBad = 0;
    bit dataOeBad = 0;
    int base;
    logic [AW-1:0] a0 = addr[AW-1:0];
    base = rdN;
    busy = busyVal;
    for (int i = 0; i < 8; i++) sendBit(op[7-i], hdrOeBad);
    busy = 1'b0;
    for (int i = 0; i < 24; i++) sendBit(addr[23-i], hdrOeBad);
    if (ignored) begin
      for (int i = 0; i < 16; i++) sendBit(i[0], hdrOeBad);
      chk(!hdrOeBad, {tag, " R7/R1 outputs stay undriven"}, hdrOeBad, 0);
      chk(rdN == base, {tag, " R7/R1 no memory reads"}, rdN - base, 0);
    end else begin
      if (fast) for (int i = 0; i < 8; i++) sendBit(dumVal ^ i[0], hdrOeBad);
      chk(!hdrOeBad, {tag, " R8 no drive in header"}, hdrOeBad, 0);
      for (int b = 0; b < nBytes; b++) begin
        logic [7:0] got = 8'h00;
        logic [7:0] exp = memf(a0 + AW'(b));
        for (int k = 0; k < per; k++) begin
          @(negedge clk);
          #2;
          if (dual) begin
            got[7-2*k] = soOut;
            got[6-2*k] = dioOut;
            if (!(soOe && dioOe)) dataOeBad = 1;
          end else begin
            got[7-k] = soOut;
            if (!(soOe && !dioOe)) dataOeBad = 1;
          end
        end
        chk(got == exp, $sformatf("%s R5 byte %0d (R2/R4/R6)", tag, b), got, exp);
      end
      for (int k = 0; k < extra; k++) begin
        @(negedge clk);
        #2;
      end
      chk(!dataOeBad, {tag, " R8 data-phase drive enables"}, dataOeBad, 0);
    end
    @(negedge clk);
    csN = 1'b1;
    #2;
    chk(!soOe && !dioOe, {tag, " R8/R9 release at chip select high"}, {soOe, dioOe}, 0);
    if (!ignored) begin
      bit seqOk = 1;
      int n = rdN - base;
      for (int i = 0; i < n; i++)
        if (reads[(base + i) % 1024] != a0 + AW'(i)) seqOk = 0;
      chk(seqOk && n >= nBytes && n <= nBytes + 3, {tag, " R10 read address sequence"}, n, nBytes);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(!soOe && !dioOe && !memRdEn, "R8 reset state", {soOe, dioOe, memRdEn}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runRead(8'h03, 24'h000100, 4, 1'b0, 1'b0, 0, 0, "plain R2");
    runRead(8'h0B, 24'h012345, 3, 1'b0, 1'b0, 0, 0, "fast dum0 R3");
    runRead(8'h0B, 24'h012345, 3, 1'b1, 1'b0, 0, 0, "fast dum1 R3");
    runRead(8'h3B, 24'h0ABCDE, 6, 1'b1, 1'b0, 0, 0, "dual R4");
    runRead(8'h3B, 24'hFFFFFE, 4, 1'b0, 1'b0, 0, 0, "dual wrap R6");
    runRead(8'h03, 24'h1FFFFF, 3, 1'b0, 1'b0, 0, 0, "plain wrap R6");
    runRead(8'h03, 24'h000040, 2, 1'b0, 1'b1, 1, 0, "busy plain R7");
    runRead(8'h3B, 24'h000040, 2, 1'b0, 1'b1, 1, 0, "busy dual R7");
    runRead(8'h05, 24'h000040, 2, 1'b0, 1'b0, 1, 0, "bad op R1");
    runRead(8'h03, 24'h003300, 1, 1'b0, 1'b0, 0, 3, "abort R9");
    runRead(8'h3B, 24'h003300, 2, 1'b0, 1'b0, 0, 1, "after abort R9");
    runRead(8'h0B, 24'h000777, 40, 1'b1, 1'b0, 0, 0, "long fast R5");

    // sweep of commands over start addresses
    for (int o = 0; o < 3; o++) begin
      for (int s = 0; s < 5; s++) begin
        logic [7:0] op = (o == 0) ? 8'h03 : (o == 1) ? 8'h0B : 8'h3B;
        logic [23:0] ad = (s == 0) ? 24'h000000 : (s == 1) ? 24'h0007FF :
                          (s == 2) ? 24'h1FFFFD : (s == 3) ? 24'h60F0F0 : 24'h15A5A5;
        runRead(op, ad, 5, s[0], 1'b0, 0, 0, "sweep R1");
      end
    end

    done = 1;
    finishRun();
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finishRun();
    end
  end
endmodule